// File: doc/BRIEF.md
# Write-Only Two-Wire Serial Slave Receiver

This block is the receive front end of a two-wire serial (I2C) slave that only accepts writes. It runs on a fast system clock that oversamples both bus lines. Each line passes through a two-flop synchronizer and a counter-based spike filter. Edges on the cleaned lines are then decoded into START, STOP and bit-clock events. A byte engine shifts in address and data bytes MSB first. It pulls SDA low to acknowledge a matching address and each data byte after it. Every data byte is presented downstream with a one-cycle strobe and a flag that marks it as the upper or lower half of a 16-bit word.

The address byte is accepted in two cases: when its upper six bits equal a fixed prefix, its seventh bit equals the select pin and its direction bit is 0, or when it equals a fixed broadcast value. The select pin is sampled once, on the first clock after reset, and is not tracked after that. A high-speed master code, any other address, and any read request are left without acknowledge. The block then stays silent until the next START or STOP. Pairing of data bytes restarts at every START, so a repeated START always begins a fresh word.

Top module: `i2c_wr_slave`

## Requirements
- R1: After reset the pull-down output `sda_pull_o` is 0 and `byte_vld_o` is 0.
- R2: A pulse on SCL or SDA that lasts fewer than FILT_CYCLES system clocks is ignored. It neither adds a bit nor creates a START or STOP.
- R3: A STOP (SDA rising while SCL is high) returns the block to idle. Bytes clocked after a STOP without a new START are neither acknowledged nor delivered.
- R4: The address byte {1,0,0,1,1,0,A,0}, where A is the captured select bit, is acknowledged. `sda_pull_o` is 0 during the eighth bit, 1 during the ninth SCL high, and 0 again once the ninth SCL falling edge has been seen.
- R5: An address byte that does not match, or whose direction bit (bit 0) is 1, is not acknowledged. No data byte that follows it is acknowledged or delivered.
- R6: The address byte 8'h90 is acknowledged whatever the captured select bit is.
- R7: The select pin is sampled on the first clock after reset. Later changes of the pin do not change which address is acknowledged.
- R8: Each data byte after an acknowledged address is delivered on `byte_o`, MSB first, with a one-cycle `byte_vld_o` pulse, and is acknowledged.
- R9: `byte_hi_o` is 1 for the first data byte after the address and then alternates 1,0,1,0 across the data bytes of the same transfer.
- R10: A repeated START returns the block to the address phase, and the first data byte after the new address is again flagged with `byte_hi_o`=1.
- R11: A byte of the form 0000_1xxx in the address position is not acknowledged. A following repeated START with a matching address is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line, sensed level |
| addr_sel_i | input | 1 | Address select bit, sampled after reset |
| sda_pull_o | output | 1 | 1 = drive SDA low (open-drain acknowledge) |
| byte_o | output | 8 | Last received data byte |
| byte_vld_o | output | 1 | One-cycle strobe for a new data byte |
| byte_hi_o | output | 1 | 1 = byte is the upper half of a word |

## Verification
The bench goes after the places where a slip in the byte engine is visible on the bus. If the acknowledge were released one edge late, the line would be held low into the next data bit. If the direction bit were not checked, a read request would be acknowledged. If the word-half flag were not cleared on a repeated START, an odd byte count would carry over and the next word would start on a low half. Spikes shorter than the filter window are placed on SCL during a low phase and on SDA during a high phase. An unfiltered design would take an extra bit from the first or see a false START or STOP from the second, and the delivered byte would be wrong. The select pin is changed after reset to catch a design that tracks it live.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] HS_TAG = 5'b00001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_DATA,
    ST_DACK,
    ST_SKIP
  } rx_state_t;
endpackage

// File: rtl/i2cw_line_filter.sv
module i2cw_line_filter #(
  parameter int   FILT_CYCLES = 13,
  parameter logic RST_LEVEL   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYCLES - 1);

  logic          s1_q, s2_q, clean_q, clean_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    clean_n = clean_q;
    cnt_n   = cnt_q;
    if (s2_q == clean_q) begin
      cnt_n = '0;
    end else if (cnt_q == CNT_LAST) begin
      clean_n = s2_q;
      cnt_n   = '0;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= RST_LEVEL;
      s2_q    <= RST_LEVEL;
      clean_q <= RST_LEVEL;
      cnt_q   <= '0;
    end else begin
      s1_q    <= raw_i;
      s2_q    <= s1_q;
      clean_q <= clean_n;
      cnt_q   <= cnt_n;
    end
  end

  assign clean_o = clean_q;

  // R2: the cleaned level only moves toward the synchronized level
  p_filt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_q != $past(clean_q)) |-> ($past(s2_q) == clean_q));
endmodule

// File: rtl/i2cw_bus_events.sv
module i2cw_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_wr_slave.sv
module i2c_wr_slave #(
  parameter int         FILT_CYCLES = 13,
  parameter logic [5:0] ADDR_PREFIX = 6'b100110,
  parameter logic [7:0] BCAST_ADDR  = 8'h90
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_sel_i,
  output logic       sda_pull_o,
  output logic [7:0] byte_o,
  output logic       byte_vld_o,
  output logic       byte_hi_o
);
  import i2cw_pkg::*;

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic [1:0] raw_lines, clean_lines;
  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2cw_line_filter #(.FILT_CYCLES(FILT_CYCLES), .RST_LEVEL(1'b1)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_lines[g]),
      .clean_o(clean_lines[g])
    );
  end

  logic scl_rise, scl_fall, start_ev, stop_ev;

  i2cw_bus_events u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (clean_lines[0]),
    .sda_i     (clean_lines[1]),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_ev),
    .stop_o    (stop_ev)
  );

  rx_state_t         state_q, state_n;
  logic [CNT_W-1:0]  bit_q, bit_n;
  logic [BYTE_W-1:0] shr_q, shr_n, out_q, out_n;
  logic              pull_q, pull_n, half_q, half_n;
  logic              vld_q, vld_n, hi_q, hi_n;
  logic              a0_q, a0_n, cap_q, cap_n;
  logic              hs_code, addr_hit, byte_done;

  assign hs_code   = (shr_q[7:3] == HS_TAG);
  assign addr_hit  = !hs_code &&
                     ((shr_q == {ADDR_PREFIX, a0_q, 1'b0}) || (shr_q == BCAST_ADDR));
  assign byte_done = scl_fall && (bit_q == LAST_BIT);

  always_comb begin
    state_n = state_q;
    bit_n   = bit_q;
    shr_n   = shr_q;
    out_n   = out_q;
    pull_n  = pull_q;
    half_n  = half_q;
    vld_n   = 1'b0;
    hi_n    = hi_q;
    a0_n    = a0_q;
    cap_n   = cap_q;
    if (!cap_q) begin
      a0_n  = addr_sel_i;
      cap_n = 1'b1;
    end
    if (stop_ev) begin
      state_n = ST_IDLE;
      pull_n  = 1'b0;
    end else if (start_ev) begin
      state_n = ST_ADDR;
      bit_n   = '0;
      pull_n  = 1'b0;
      half_n  = 1'b1;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_DATA: begin
          if (scl_rise && (bit_q != LAST_BIT)) begin
            shr_n = {shr_q[BYTE_W-2:0], clean_lines[1]};
            bit_n = bit_q + 1'b1;
          end else if (byte_done) begin
            if (state_q == ST_ADDR) begin
              state_n = addr_hit ? ST_AACK : ST_SKIP;
              pull_n  = addr_hit;
            end else begin
              out_n   = shr_q;
              vld_n   = 1'b1;
              hi_n    = half_q;
              half_n  = ~half_q;
              state_n = ST_DACK;
              pull_n  = 1'b1;
            end
          end
        end
        ST_AACK, ST_DACK: begin
          if (scl_fall) begin
            pull_n  = 1'b0;
            bit_n   = '0;
            state_n = ST_DATA;
            if (state_q == ST_AACK) half_n = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      shr_q   <= '0;
      out_q   <= '0;
      pull_q  <= 1'b0;
      half_q  <= 1'b1;
      vld_q   <= 1'b0;
      hi_q    <= 1'b0;
      a0_q    <= 1'b0;
      cap_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      bit_q   <= bit_n;
      shr_q   <= shr_n;
      out_q   <= out_n;
      pull_q  <= pull_n;
      half_q  <= half_n;
      vld_q   <= vld_n;
      hi_q    <= hi_n;
      a0_q    <= a0_n;
      cap_q   <= cap_n;
    end
  end

  assign sda_pull_o = pull_q;
  assign byte_o     = out_q;
  assign byte_vld_o = vld_q;
  assign byte_hi_o  = hi_q;

  p_stop_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state_q == ST_IDLE) && !sda_pull_o);

  p_pull_in_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> (state_q == ST_AACK) || (state_q == ST_DACK));

  p_pull_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o && scl_fall) |=> !sda_pull_o);

  p_a0_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q |=> $stable(a0_q));

  p_vld_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |=> !byte_vld_o);

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && !stop_ev) |=> (state_q == ST_ADDR) && (bit_q == '0) && half_q);

  p_hs_nack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_ADDR) && byte_done && hs_code && !start_ev && !stop_ev)
      |=> !sda_pull_o && (state_q == ST_SKIP));
endmodule

// File: tb/i2c_wr_slave_bench.sv
module i2c_wr_slave_bench;
  localparam int FILT = 13;
  localparam int Q    = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic addr_sel = 1'b0;
  logic sda_pull, byte_vld, byte_hi;
  logic [7:0] byte_d;
  logic sda_line;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  i2c_wr_slave #(.FILT_CYCLES(FILT)) u_i2c_wr_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel_i(addr_sel), .sda_pull_o(sda_pull), .byte_o(byte_d),
    .byte_vld_o(byte_vld), .byte_hi_o(byte_hi)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] cap_d [0:63];
  logic       cap_h [0:63];
  int cap_n = 0;

  always @(negedge clk) begin
    if (rst_n && byte_vld) begin
      cap_d[cap_n[5:0]] = byte_d;
      cap_h[cap_n[5:0]] = byte_hi;
      cap_n = cap_n + 1;
    end
  end

  // {address, first data, second data, expect ack}
  localparam logic [24:0] VEC [8] = '{
    {8'h98, 8'hA5, 8'h3C, 1'b1},
    {8'h9A, 8'h12, 8'h34, 1'b0},
    {8'h99, 8'h55, 8'hAA, 1'b0},
    {8'h90, 8'h0F, 8'hF0, 1'b1},
    {8'h0B, 8'h11, 8'h22, 1'b0},
    {8'h00, 8'h77, 8'h88, 1'b0},
    {8'h98, 8'hFF, 8'h00, 1'b1},
    {8'h18, 8'h66, 8'h99, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic sel);
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; addr_sel = sel;
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
  endtask

  task automatic bus_start();
    sda_m = 1'b0; wclk(2*Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic bus_restart();
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    sda_m = 1'b1; wclk(2*Q);
  endtask

  // gl: 0 none, 1 short SCL pulse while low, 2 short SDA dip while high
  task automatic send_bit(input logic b, input int gl, output logic pull_hi);
    sda_m = b;
    if (gl == 1) begin
      wclk(Q/2); scl_m = 1'b1; wclk(5); scl_m = 1'b0; wclk(Q - Q/2 - 5);
    end else wclk(Q);
    scl_m = 1'b1;
    wclk(Q);
    pull_hi = sda_pull;
    if (gl == 2) begin
      sda_m = 1'b0; wclk(5); sda_m = 1'b1; wclk(Q - 5);
    end else wclk(Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, input int gl,
                           output logic ack, output logic pre_pull, output logic post_pull);
    logic ph;
    for (int i = 7; i >= 0; i--) begin
      send_bit(v[i], (i == 3) ? gl : 0, ph);
      if (i == 0) pre_pull = ph;
    end
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    ack = ~sda_line;
    wclk(Q);
    scl_m = 1'b0; wclk(Q);
    post_pull = sda_pull;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a, pre, post;
    int base;
    do_reset(1'b0);
    chk(sda_pull == 1'b0, "R1 pull after reset", sda_pull, 0);
    chk(byte_vld == 1'b0, "R1 strobe after reset", byte_vld, 0);

    for (int k = 0; k < 8; k++) begin
      logic [7:0] ad, d0, d1;
      logic ex;
      {ad, d0, d1, ex} = VEC[k];
      base = cap_n;
      bus_start();
      send_byte(ad, 0, a, pre, post);
      chk(a == ex, (ex ? "R4/R6 address ack" : "R5/R11 address nack"), a, ex);
      if (ex) begin
        chk(pre == 1'b0, "R4 no pull during bit 8", pre, 0);
        chk(post == 1'b0, "R4 pull released after bit 9", post, 0);
      end
      send_byte(d0, 0, a, pre, post);
      chk(a == ex, "R8/R5 first data ack", a, ex);
      send_byte(d1, 0, a, pre, post);
      chk(a == ex, "R8/R5 second data ack", a, ex);
      bus_stop();
      chk(cap_n - base == (ex ? 2 : 0), "R8/R5 strobe count", cap_n - base, ex ? 2 : 0);
      if (ex && cap_n - base == 2) begin
        chk(cap_d[base] == d0, "R8 first byte", cap_d[base], d0);
        chk(cap_d[base+1] == d1, "R8 second byte", cap_d[base+1], d1);
        chk(cap_h[base] == 1'b1 && cap_h[base+1] == 1'b0, "R9 halves",
            {cap_h[base], cap_h[base+1]}, 2'b10);
      end
    end

    // R9: three words in one transfer
    base = cap_n;
    bus_start();
    send_byte(8'h98, 0, a, pre, post);
    for (int j = 0; j < 6; j++) send_byte(8'h40 + 8'(j), 0, a, pre, post);
    bus_stop();
    chk(cap_n - base == 6, "R9 word count", cap_n - base, 6);
    for (int j = 0; j < 6; j++)
      chk(cap_h[base+j] == ((j % 2) == 0), "R9 alternation", cap_h[base+j], (j % 2) == 0);

    // R2: short spikes on SCL (low phase) and SDA (high phase)
    base = cap_n;
    bus_start();
    send_byte(8'h98, 0, a, pre, post);
    send_byte(8'h5B, 1, a, pre, post);
    chk(a == 1'b1, "R2 ack with SCL spike", a, 1);
    send_byte(8'h5B, 2, a, pre, post);
    chk(a == 1'b1, "R2 ack with SDA spike", a, 1);
    bus_stop();
    chk(cap_n - base == 2, "R2 strobe count", cap_n - base, 2);
    chk(cap_d[base] == 8'h5B, "R2 byte with SCL spike", cap_d[base], 8'h5B);
    chk(cap_d[base+1] == 8'h5B, "R2 byte with SDA spike", cap_d[base+1], 8'h5B);

    // R10: odd byte count then repeated START
    base = cap_n;
    bus_start();
    send_byte(8'h98, 0, a, pre, post);
    send_byte(8'hC3, 0, a, pre, post);
    bus_restart();
    send_byte(8'h98, 0, a, pre, post);
    chk(a == 1'b1, "R10 ack after repeated start", a, 1);
    send_byte(8'h3C, 0, a, pre, post);
    bus_stop();
    chk(cap_n - base == 2, "R10 strobe count", cap_n - base, 2);
    chk(cap_h[base+1] == 1'b1, "R10 new word starts high", cap_h[base+1], 1);

    // R11: high-speed master code, then repeated START
    base = cap_n;
    bus_start();
    send_byte(8'h0D, 0, a, pre, post);
    chk(a == 1'b0, "R11 master code nack", a, 0);
    bus_restart();
    send_byte(8'h98, 0, a, pre, post);
    chk(a == 1'b1, "R11 address ack after code", a, 1);
    send_byte(8'hE1, 0, a, pre, post);
    bus_stop();
    chk(cap_n - base == 1 && cap_d[base] == 8'hE1, "R11 data after code", cap_d[base], 8'hE1);

    // R3: bytes after STOP without START
    base = cap_n;
    send_byte(8'h98, 0, a, pre, post);
    chk(a == 1'b0, "R3 no ack without start", a, 0);
    send_byte(8'hAA, 0, a, pre, post);
    chk(a == 1'b0, "R3 data no ack without start", a, 0);
    bus_stop();
    chk(cap_n - base == 0, "R3 no strobe without start", cap_n - base, 0);

    // R7: select pin captured once after reset
    do_reset(1'b1);
    addr_sel = 1'b0;
    wclk(5);
    bus_start();
    send_byte(8'h9A, 0, a, pre, post);
    chk(a == 1'b1, "R7 captured select bit", a, 1);
    bus_stop();
    bus_start();
    send_byte(8'h98, 0, a, pre, post);
    chk(a == 1'b0, "R7 live pin ignored", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'h90, 0, a, pre, post);
    chk(a == 1'b1, "R6 broadcast with select 1", a, 1);
    bus_stop();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule